// File: doc/BRIEF.md
# Multi-Port GPIO Data Register Bank

This block holds the data registers for five 8-bit general-purpose I/O ports and places them in host I/O space. The window starts at a base address supplied from outside the block. After reset the base is normally E900h. Each register holds a data latch. For every pin set as an output, the latch drives the pin's output level and enables its buffer. A separate configuration register supplies one direction bit per pin on the `pin_dir` input, where 1 means output and 0 means input.

A host write stores only the bits whose pins are outputs. Bits whose pins are inputs are left unchanged. A host read is assembled bit by bit. Output pins return the latched bit. Input pins return the pin level, taken through a two-stage synchronizer. Addresses outside the five-register window are not claimed: reads return FFh and writes change nothing. The pad buffers sit outside the block and connect through separate output, output-enable and input vectors.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, every port latch is 00h, so `pin_out` is all zeros.
- R2: The window offset is `io_addr - base_addr`. Offsets 0 to 4 select, in that order, the ports labelled 1, 3, 4, 5 and 6. These are bit slices [8k+7:8k] of `pin_dir`, `pin_in`, `pin_out` and `pin_oe` for offset k. An access changes no other port.
- R3: A write stores `io_wdata` bit i in the selected latch when `pin_dir` bit i of that port is 1. The new value appears on `pin_out` after the next rising clock edge.
- R4: A write leaves latch bit i unchanged when `pin_dir` bit i is 0.
- R5: A read (`io_rd`=1, combinational on `io_rdata`) returns the latched bit for every output pin, whatever level is on `pin_in`.
- R6: A read returns the synchronized `pin_in` level for every input pin. A change on `pin_in` first shows after the second rising edge that follows it.
- R7: `pin_oe` equals `pin_dir` for every pin, and `pin_out` always carries the latch.
- R8: A read at offset 5 or above, below the base, or with `io_rd`=0 returns FFh. A write there changes no latch.
- R9: When a pin turns from input to output, it drives the latch value it already held.
- R10: A change of `base_addr` moves the whole window, and the old addresses are no longer claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_addr | input | 16 | Window base address from configuration |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (FFh when not claimed) |
| pin_dir | input | 40 | Per-pin direction, 1 = output |
| pin_in | input | 40 | Pin levels from the pads |
| pin_out | output | 40 | Output levels to the pads |
| pin_oe | output | 40 | Output enables to the pads |

## Verification
The hardest case to reach is a port whose direction bits mix inputs and outputs, where the pin levels disagree with both the latch and the write data. Only in that case do the write mask and the read mix each matter on every bit. The stimulus sweeps all five ports through several computed direction patterns. For each one it drives pins with the complement-like pattern `data ^ 96h` and lets them settle past the synchronizer. It then writes and reads back, comparing against a per-bit model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PORT_W = 8;
  typedef logic [PORT_W-1:0] port_t;

  // next latch value: output bits take new data, input bits keep old
  function automatic port_t latch_merge(port_t held, port_t wdata, port_t dir);
    return (wdata & dir) | (held & ~dir);
  endfunction

  // read view: latch for outputs, synchronized pin for inputs
  function automatic port_t read_mix(port_t held, port_t pins, port_t dir);
    return (held & dir) | (pins & ~dir);
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
  parameter int ADDR_W    = 16,
  parameter int NUM_PORTS = 5,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    base_addr,
  input  logic [ADDR_W-1:0]    io_addr,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_PORTS-1:0] sel
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = io_addr - base_addr;
    hit    = (offset < ADDR_W'(NUM_PORTS));
    idx    = IDX_W'(offset);
    for (int p = 0; p < NUM_PORTS; p++)
      sel[p] = hit && (offset == ADDR_W'(p));
  end

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  assert_outside_unclaimed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_addr - base_addr) >= ADDR_W'(NUM_PORTS)) |-> (sel == '0));
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 40,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice
  import gpio_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  port_t wdata,
  input  port_t dir,
  input  port_t pins_sync,
  output port_t latch_q,
  output port_t rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= '0;
    else if (wr_en) latch_q <= latch_merge(latch_q, wdata, dir);
  end

  assign rd_val = read_mix(latch_q, pins_sync, dir);

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((latch_q & $past(dir)) == ($past(wdata) & $past(dir))));
  assert_input_bits_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((latch_q ^ $past(latch_q)) & ~$past(dir)) == '0));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(latch_q));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_PORTS   = 5,
  parameter int SYNC_STAGES = 2,
  localparam int PINS       = NUM_PORTS * PORT_W,
  localparam int IDX_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [PORT_W-1:0] io_wdata,
  output logic [PORT_W-1:0] io_rdata,
  input  logic [PINS-1:0]   pin_dir,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  logic                 win_hit;
  logic [IDX_W-1:0]     win_idx;
  logic [NUM_PORTS-1:0] win_sel;
  logic [PINS-1:0]      pins_sync;
  port_t                rd_vals [NUM_PORTS];

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_dec (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .io_addr(io_addr),
    .hit(win_hit), .idx(win_idx), .sel(win_sel));

  gpio_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pins_sync));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_t latch_q;
    gpio_port_slice u_slice (
      .clk(clk), .rst_n(rst_n),
      .wr_en(io_wr && win_sel[p]),
      .wdata(io_wdata),
      .dir(pin_dir[p*PORT_W +: PORT_W]),
      .pins_sync(pins_sync[p*PORT_W +: PORT_W]),
      .latch_q(latch_q),
      .rd_val(rd_vals[p]));
    assign pin_out[p*PORT_W +: PORT_W] = latch_q;
  end

  assign pin_oe = pin_dir;

  always_comb begin
    io_rdata = '1;
    if (io_rd && win_hit) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (win_idx == IDX_W'(p)) io_rdata = rd_vals[p];
    end
  end

  assert_stray_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !win_hit) |=> $stable(pin_out));
  assert_no_access_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd) |-> (io_rdata == '1));
endmodule

// File: tb/tb_gpio_port_bank.sv
module tb_gpio_port_bank;
  localparam int NP = 5;
  localparam int PW = 8;
  localparam int PN = NP * PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   base_addr = 16'hE900;
  logic [15:0]   io_addr = '0;
  logic          io_wr = 1'b0;
  logic          io_rd = 1'b0;
  logic [7:0]    io_wdata = '0;
  logic [7:0]    io_rdata;
  logic [PN-1:0] pin_dir = '0;
  logic [PN-1:0] pin_in = '0;
  logic [PN-1:0] pin_out;
  logic [PN-1:0] pin_oe;

  int total = 0;
  int fails = 0;
  logic [7:0] lat_m [NP];

  always #4 clk = ~clk;

  gpio_port_bank dut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pin_dir(pin_dir), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PN-1:0] model_pins();
    logic [PN-1:0] v;
    for (int k = 0; k < NP; k++) v[k*PW +: PW] = lat_m[k];
    return v;
  endfunction

  function automatic logic [7:0] model_read(input int k);
    logic [7:0] r;
    for (int b = 0; b < PW; b++)
      r[b] = pin_dir[k*PW+b] ? lat_m[k][b] : pin_in[k*PW+b];
    return r;
  endfunction

  task automatic host_write(input logic [15:0] a, input logic [7:0] d);
    int off;
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    off = int'(16'(a - base_addr));
    if (off < NP)
      for (int b = 0; b < PW; b++)
        if (pin_dir[off*PW+b]) lat_m[off][b] = d[b];
  endtask

  task automatic host_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    for (int k = 0; k < NP; k++) lat_m[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 pin_out after reset", 64'(pin_out), 64'(0));
    pin_dir = '1;
    for (int k = 0; k < NP; k++) begin
      host_read(16'hE900 + 16'(k), rd);
      chk("R1 read after reset", 64'(rd), 64'(8'h00));
    end

    // R2 R3 R4 R5 R6 R7 sweep of ports and direction patterns
    for (int k = 0; k < NP; k++) begin
      for (int p = 0; p < 6; p++) begin
        logic [7:0] dp, dd;
        dp = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'((p * 37 + k * 91) ^ 8'h5A);
        dd = 8'(~dp + 8'(p * 17 + k));
        @(negedge clk);
        pin_dir[k*PW +: PW] = dp;
        pin_in[k*PW +: PW]  = dd ^ 8'h96;
        repeat (3) @(posedge clk);
        host_write(base_addr + 16'(k), dd);
        chk("R2 R3 R4 pin_out all ports", 64'(pin_out), 64'(model_pins()));
        chk("R7 pin_oe follows dir", 64'(pin_oe), 64'(pin_dir));
        host_read(base_addr + 16'(k), rd);
        chk("R5 R6 mixed read", 64'(rd), 64'(model_read(k)));
      end
    end

    // R6 synchronizer latency on port 0 input bits
    @(negedge clk);
    pin_dir[7:0] = 8'h00; pin_in[7:0] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) pin_in[7:0] = 8'hFF;
    @(posedge clk);
    host_read(base_addr, rd);
    chk("R6 one edge after change", 64'(rd), 64'(8'h00));
    @(posedge clk); #1;
    io_addr = base_addr; io_rd = 1'b1; #1 rd = io_rdata; io_rd = 1'b0;
    chk("R6 two edges after change", 64'(rd), 64'(8'hFF));

    // R5 output bit ignores pin level
    @(negedge clk) pin_dir[15:8] = 8'hFF;
    host_write(base_addr + 16'd1, 8'h3C);
    @(negedge clk) pin_in[15:8] = 8'hC3;
    repeat (3) @(posedge clk);
    host_read(base_addr + 16'd1, rd);
    chk("R5 latch not pin", 64'(rd), 64'(8'h3C));

    // R9 input to output turn keeps held latch
    @(negedge clk) pin_dir[23:16] = 8'hFF;
    host_write(base_addr + 16'd2, 8'h5A);
    @(negedge clk) pin_dir[23:16] = 8'h00;
    host_write(base_addr + 16'd2, 8'hA5);
    @(negedge clk) pin_dir[23:16] = 8'hFF;
    #1 chk("R9 held value driven", 64'(pin_out[23:16]), 64'(8'h5A));
    chk("R9 R4 model agrees", 64'(pin_out), 64'(model_pins()));

    // R8 unclaimed addresses
    pin_dir = '1;
    host_read(base_addr + 16'd5, rd);
    chk("R8 read offset 5", 64'(rd), 64'(8'hFF));
    host_read(base_addr - 16'd1, rd);
    chk("R8 read below base", 64'(rd), 64'(8'hFF));
    host_write(base_addr + 16'd5, 8'h00);
    host_write(base_addr - 16'd1, 8'h00);
    host_write(base_addr + 16'h100, 8'h00);
    chk("R8 stray writes inert", 64'(pin_out), 64'(model_pins()));
    @(negedge clk) io_addr = base_addr;
    #1 chk("R8 no strobe reads FF", 64'(io_rdata), 64'(8'hFF));

    // R10 moved base
    @(negedge clk) base_addr = 16'h0300;
    host_write(16'hE904, 8'h11);
    chk("R10 old base unclaimed", 64'(pin_out), 64'(model_pins()));
    host_write(16'h0304, 8'h77);
    chk("R10 new base claimed", 64'(pin_out), 64'(model_pins()));
    host_read(16'h0304, rd);
    chk("R10 new base read", 64'(rd), 64'(8'h77));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule